// File: doc/BRIEF.md
# Asynchronous Parallel ROM Word-Read Controller

This block is a clocked bus master that fetches 16-bit words from an asynchronous parallel ROM. The ROM has a chip-enable and an output-enable, both active low. A host pulses a request with an 18-bit word address. The controller drives the address and chip-enable, and it holds output-enable back until the last cycle that still lets the data arrive in time. It then captures the data on a fixed clock edge and returns it with a one-cycle strobe. After that it waits out the output-float time before it reports the shared data bus free again.

All waits are parameters given in nanoseconds and turned into clock counts: ceil(time / clock period), plus a sampling margin on the access and output-enable paths. A parameter chooses between two ways of running the chip-enable. In the parking mode the chip-enable returns high (standby) after every read. In the streaming mode it stays low once the first read has been issued, so that reads can run back to back.

With the default parameters (20 ns clock, 55 ns access, 20 ns output-enable delay, 20 ns float, margin 1) the counts are as follows. Access takes 4 cycles, the output-enable path takes 2 cycles, output-enable falls 2 cycles after chip-enable, and the float wait is 1 cycle.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1, `ack` is 0 and `idle` is 1.
- R2: `req` is sampled only on an edge where `idle` is 1. The address is captured on that edge. A `req` pulse while `idle` is 0 produces no extra read, and changes on `addr` during an access do not alter `rom_addr` or the returned word.
- R3: `rom_ce_n` falls and `rom_addr` takes the captured address on the accepting edge. `rom_oe_n` falls exactly 2 cycles later, and it is never low while `rom_ce_n` is high.
- R4: `rdata` holds the ROM word at the captured address, and `ack` is high for exactly one cycle, starting 4 cycles after the accepting edge.
- R5: `rom_oe_n` returns high on the same edge that captures the data. In parking mode `rom_ce_n` also returns high on that edge.
- R6: `idle` rises only after the float wait (1 cycle) that follows the rise of `rom_oe_n`. A second driver granted the bus when `idle` is 1 never overlaps a ROM that is still driving.
- R7: In parking mode `rom_ce_n` is 1 whenever `idle` is 1. In streaming mode `rom_ce_n` stays 0 after the first read, including while idle.
- R8: `rom_addr` does not change while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, sampled when idle |
| addr | input | 18 | Word address for the request |
| idle | output | 1 | Controller idle and bus floated; a request may be issued |
| ack | output | 1 | One-cycle strobe marking rdata valid |
| rdata | output | 16 | Captured word |
| rom_addr | output | 18 | Address to the ROM |
| rom_ce_n | output | 1 | ROM chip-enable, active low |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_data | input | 16 | Data from the ROM |

## Verification
The capture of `rom_data` and the release of output-enable (and of chip-enable in parking mode) happen on the same clock edge, because the ROM holds its data for 0 ns after any control change. The bench tests this with a ROM model that has real nanosecond timing. The model drives a garbage pattern whenever the access, chip-enable or output-enable time has not yet been met, and also once output-enable or chip-enable is high again. A capture that comes too late or too early therefore shows up as a data mismatch in the scoreboard. The same model tracks the float time, and the bench flags any cycle in which `idle` is 1 while the ROM is still driving.

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 20,
  parameter int T_ACC_NS     = 55,
  parameter int T_OE_NS      = 20,
  parameter int T_DF_NS      = 20,
  parameter int MARGIN       = 1,
  parameter bit PARK_STANDBY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              idle,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_data
);
  localparam int ACC_CYC = (T_ACC_NS + CLK_NS - 1) / CLK_NS + MARGIN;
  localparam int OE_CYC  = (T_OE_NS + CLK_NS - 1) / CLK_NS + MARGIN;
  localparam int OE_DLY  = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int DF_RAW  = (T_DF_NS + CLK_NS - 1) / CLK_NS;
  localparam int DF_CYC  = (DF_RAW > 0) ? DF_RAW : 1;
  localparam int CW      = $clog2(ACC_CYC + DF_CYC + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FLT} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rom_ce_n <= 1'b1;
      rom_oe_n <= 1'b1;
      ack      <= 1'b0;
      rdata    <= '0;
      rom_addr <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          rom_addr <= addr;
          rom_ce_n <= 1'b0;
          rom_oe_n <= (OE_DLY != 0);
          cnt      <= '0;
          st       <= S_ACC;
        end
        S_ACC: begin
          cnt <= cnt + 1'b1;
          if (OE_DLY != 0 && cnt == CW'(OE_DLY - 1)) rom_oe_n <= 1'b0;
          if (cnt == CW'(ACC_CYC - 1)) begin
            rdata    <= rom_data;
            ack      <= 1'b1;
            rom_oe_n <= 1'b1;
            if (PARK_STANDBY) rom_ce_n <= 1'b1;
            cnt      <= '0;
            st       <= S_FLT;
          end
        end
        S_FLT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DF_CYC - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  oe_off_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> rom_oe_n);

  // R7
  park_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PARK_STANDBY && idle) |-> rom_ce_n);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC && $past(st) == S_ACC) |-> $stable(rom_addr));

  // R2
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !req) |=> idle);

  // R6
  float_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> (rom_oe_n && $past(rom_oe_n)));
endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module rom_model #(
  parameter real T_ACC = 55.0,
  parameter real T_OE  = 20.0,
  parameter real T_DF  = 20.0
) (
  input  logic [17:0] a,
  input  logic        ce_n,
  input  logic        oe_n,
  output logic [15:0] d,
  output logic        drv
);
  realtime ta = -1000.0, tc = -1000.0, to = -1000.0, tf = -1000.0;
  always @(a)            ta = $realtime;
  always @(negedge ce_n) tc = $realtime;
  always @(negedge oe_n) to = $realtime;
  always @(posedge ce_n or posedge oe_n) tf = $realtime;
  initial begin
    d = 16'hDEAD; drv = 1'b0;
    forever begin
      #1;
      if (!ce_n && !oe_n && ($realtime - ta >= T_ACC) && ($realtime - tc >= T_ACC)
          && ($realtime - to >= T_OE))
        d = 16'(a * 18'd7 + 18'h3C5A);
      else
        d = 16'hDEAD;
      drv = (!ce_n && !oe_n) || ($realtime - tf < T_DF);
    end
  end
endmodule

module eprom_rd_ctrl_tb;
  logic clk = 0, rst_n = 0, req = 0;
  logic [17:0] addr = '0;
  logic        idle_p, ack_p, ce_p, oe_p, drv_p;
  logic        idle_b, ack_b, ce_b, oe_b, drv_b;
  logic [15:0] rd_p, rd_b, rom_p, rom_b;
  logic [17:0] ra_p, ra_b;
  int total = 0, bad = 0, cyc = 0;
  int exp_d[$], exp_c[$], exp_oe[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eprom_rd_ctrl u_dut (.clk, .rst_n, .req, .addr, .idle(idle_p), .ack(ack_p), .rdata(rd_p),
    .rom_addr(ra_p), .rom_ce_n(ce_p), .rom_oe_n(oe_p), .rom_data(rom_p));
  eprom_rd_ctrl #(.PARK_STANDBY(1'b0)) u_bb (.clk, .rst_n, .req, .addr, .idle(idle_b),
    .ack(ack_b), .rdata(rd_b), .rom_addr(ra_b), .rom_ce_n(ce_b), .rom_oe_n(oe_b),
    .rom_data(rom_b));
  rom_model m_p (.a(ra_p), .ce_n(ce_p), .oe_n(oe_p), .d(rom_p), .drv(drv_p));
  rom_model m_b (.a(ra_b), .ce_n(ce_b), .oe_n(oe_b), .d(rom_b), .drv(drv_b));

  function automatic logic [15:0] word(input logic [17:0] a);
    return 16'(a * 18'd7 + 18'h3C5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, expv, $realtime);
    end
  endtask

  task automatic do_read(input logic [17:0] a, input bit poke);
    @(negedge clk);
    while (!idle_p) @(negedge clk);
    req = 1; addr = a;
    exp_d.push_back(int'(word(a)));
    exp_c.push_back(cyc + 5);
    exp_oe.push_back(cyc + 3);
    @(negedge clk); req = 0; addr = ~a;
    if (poke) begin
      @(negedge clk); req = 1; addr = a ^ 18'h155;
      @(negedge clk); req = 0;
    end
  endtask

  logic pi_p = 1, pi_b = 1, po_p = 1;
  int   nreads_b = 0;
  always @(negedge clk) if (rst_n) begin
    if (ack_p) begin
      if (exp_d.size() == 0) chk(0, "R2 spurious ack", 1, 0);
      else begin
        int ed, ec;
        ed = exp_d.pop_front(); ec = exp_c.pop_front();
        chk(rd_p == 16'(ed), "R4 data park", rd_p, ed);
        chk(rd_b == 16'(ed), "R4 data stream", rd_b, ed);
        chk(cyc == ec, "R4 ack cycle", cyc, ec);
        chk(oe_p && ce_p, "R5 release park", {oe_p, ce_p}, 3);
        chk(oe_b && !ce_b, "R5 release stream", {oe_b, ce_b}, 2);
      end
      chk(ack_b, "R4 ack both", ack_b, 1);
      nreads_b++;
    end
    if (!oe_p && po_p) begin
      int eo;
      eo = (exp_oe.size() != 0) ? exp_oe.pop_front() : -1;
      chk(cyc == eo, "R3 oe delay", cyc, eo);
    end
    if (idle_p && !pi_p) begin
      chk(!drv_p, "R6 overlap park", drv_p, 0);
      chk(ce_p, "R7 standby park", ce_p, 1);
    end
    if (idle_b && !pi_b) begin
      chk(!drv_b, "R6 overlap stream", drv_b, 0);
      chk(!ce_b, "R7 ce held stream", ce_b, 0);
    end
    pi_p = idle_p; pi_b = idle_b; po_p = oe_p;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_p && oe_p, "R1 ctrl high in reset", {ce_p, oe_p}, 3);
    chk(!ack_p && idle_p, "R1 ack/idle in reset", {ack_p, idle_p}, 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(ce_p && oe_p && ce_b && oe_b, "R1 ctrl after reset", {ce_p, oe_p}, 3);
    chk(!ack_p && idle_p && idle_b, "R1 idle after reset", idle_p, 1);
    do_read(18'h00000, 0);
    do_read(18'h3FFFF, 0);
    do_read(18'h12345, 1);
    do_read(18'h2AAAA, 0);
    do_read(18'h15555, 1);
    do_read(18'h00001, 0);
    repeat (12) @(negedge clk);
    chk(exp_d.size() == 0, "R2 all reads acked", exp_d.size(), 0);
    chk(nreads_b == 6, "R2 read count", nreads_b, 6);
    chk(ra_p == 18'h00001, "R2 addr kept", ra_p, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule